// File: doc/BRIEF.md
# Guarded Status Register with Write-Enable Sequencing

This block is the status and control byte that stands in front of a clock/control register space. Writes into that space pass only after a two-step arming sequence, which software performs by writing fixed patterns into the status byte. The first latch is set, then the second. The block also collects two alarm-match flags that clear when the status byte is read. It mirrors three hardware-owned conditions into read-only bits: running on the backup supply, an oscillator fault, and a total loss of power.

A serial bus engine sits in front of the block. It presents byte-wide accesses as an address, a write strobe with data, a read-start strobe and a read-done strobe. The read-done strobe marks the moment the final data bit of a byte has gone out. The block keeps the bus engine's address pointer so that a current-address read can continue where the last access stopped. It gives a write gate for the guarded space and acknowledges every write, including one it discards. Because the status byte supports single-byte access only, the block pulses an end-of-operation signal once any status access completes.

Top module: `stat_guard_reg`

## Requirements
- R1: While reset is asserted, `stat_byte` reads 0x01 and `cur_ptr` reads 0. The status byte layout is: bit 7 backup-supply flag, bit 6 alarm 1 flag, bit 5 alarm 0 flag, bit 4 oscillator-fault flag, bit 3 constant 0, bit 2 second latch (RWEL), bit 1 first latch (WEL), bit 0 power-loss flag.
- R2: A write of 0x02 to the status address 0x3F sets WEL and clears RWEL. The change is visible after the clock edge that takes the write.
- R3: A write of 0x06 to 0x3F sets RWEL only if WEL is already 1. With WEL at 0, the write changes nothing.
- R4: A write of 0x00 to 0x3F clears both latches. A write of any other value to 0x3F leaves both latches unchanged.
- R5: `guard_we` is high in the same cycle as `bus_wr` only when `bus_addr` is not 0x3F and both latches are 1. `wr_ack` follows `bus_wr` for every write, including a discarded one. `wr_permit` is high exactly when both latches are 1.
- R6: A high bit on `alm_hit` (bit 0 for alarm 0, bit 1 for alarm 1) sets the matching flag after that clock edge.
- R7: When `rd_done` ends a read that began at 0x3F, only the alarm flags that were set when `rd_start` began that read are cleared. A flag set during the read stays set, and so does a flag whose `alm_hit` is high in the same cycle as `rd_done`. A read of any other address clears no flag.
- R8: The status bits for backup supply, oscillator fault and power loss follow `on_backup`, `osc_bad` and `pwr_lost` after exactly SYNC_STAGES (default 2) clock edges. Writes never change these bits or bit 3.
- R9: A write loads `cur_ptr` with `bus_addr`+1. A `rd_start` loads it with `bus_addr`, or leaves it at its current value when `rd_cur` is 1. A `rd_done` that follows a `rd_start` adds 1 modulo 64, and a `rd_done` with no read open is ignored. `bus_wr` has priority over `rd_start`, which has priority over `rd_done`.
- R10: `op_end` is high for exactly one cycle after a write to 0x3F or the completion of a read at 0x3F, and stays low after accesses to other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| rd_start | input | 1 | Start of a byte read |
| rd_cur | input | 1 | Read uses the held pointer instead of bus_addr |
| rd_done | input | 1 | Last data bit of the read byte has completed |
| alm_hit | input | 2 | Alarm match events, bit i for alarm i |
| on_backup | input | 1 | Device runs from the backup supply |
| osc_bad | input | 1 | Oscillator fault indication |
| pwr_lost | input | 1 | Total power loss has occurred |
| stat_byte | output | 8 | Current status byte |
| cur_ptr | output | 6 | Held register address pointer |
| wr_permit | output | 1 | Both write-enable latches are set |
| guard_we | output | 1 | Write strobe into the guarded space |
| wr_ack | output | 1 | Write acknowledged |
| op_end | output | 1 | Status access complete, burst must stop |

## Verification
`guard_we` and `wr_ack` are combinational and are due in the cycle of the strobe. The bench samples them one time unit after driving the inputs, before the clock edge. The latches, alarm flags, pointer and `op_end` are due right after the edge that takes the stimulus, and the bench samples them two time units after that edge. The hardware-owned bits are due SYNC_STAGES edges later. The bench checks that they are still unchanged one edge early and that they have changed on the expected edge.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int BYTE_W = 8;
  localparam int N_ALM  = 2;

  localparam int POS_BAT  = 7;
  localparam int POS_AL1  = 6;
  localparam int POS_AL0  = 5;
  localparam int POS_OSCF = 4;
  localparam int POS_RSV  = 3;
  localparam int POS_RWEL = 2;
  localparam int POS_WEL  = 1;
  localparam int POS_RTCF = 0;

  localparam logic [BYTE_W-1:0] PAT_ARM1  = 8'h02;
  localparam logic [BYTE_W-1:0] PAT_ARM2  = 8'h06;
  localparam logic [BYTE_W-1:0] PAT_DISARM = 8'h00;

  typedef enum logic [1:0] {
    LAT_HOLD   = 2'd0,
    LAT_ARM1   = 2'd1,
    LAT_ARM2   = 2'd2,
    LAT_DISARM = 2'd3
  } lat_op_e;

  function automatic lat_op_e decode_lat(input logic [BYTE_W-1:0] d);
    lat_op_e op;
    if (d == PAT_ARM1)        op = LAT_ARM1;
    else if (d == PAT_ARM2)   op = LAT_ARM2;
    else if (d == PAT_DISARM) op = LAT_DISARM;
    else                      op = LAT_HOLD;
    return op;
  endfunction
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] pipe_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb pipe_d[s] = d;
      end else begin : g_rest
        always_comb pipe_d[s] = pipe_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= RST_VAL;
        else        pipe_q[s] <= pipe_d[s];
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sg_latch_seq.sv
module sg_latch_seq
  import sg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              wel,
  output logic              rwel
);
  lat_op_e op;
  logic    wel_q, wel_d;
  logic    rwel_q, rwel_d;
  logic    lat_en;

  always_comb begin
    op     = decode_lat(wdata);
    lat_en = wr_sr;
    wel_d  = wel_q;
    rwel_d = rwel_q;
    case (op)
      LAT_ARM1: begin
        wel_d  = 1'b1;
        rwel_d = 1'b0;
      end
      LAT_ARM2: begin
        if (wel_q) rwel_d = 1'b1;
      end
      LAT_DISARM: begin
        wel_d  = 1'b0;
        rwel_d = 1'b0;
      end
      default: begin
        wel_d  = wel_q;
        rwel_d = rwel_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (lat_en) begin
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
    end
  end

  assign wel  = wel_q;
  assign rwel = rwel_q;
endmodule

// File: rtl/sg_alarm_bank.sv
module sg_alarm_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         snap_en,
  input  logic         clr_en,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] snap_q, snap_d;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_alm
      always_comb begin
        snap_d[i] = snap_en ? flag_q[i] : snap_q[i];
        flag_d[i] = flag_q[i];
        if (clr_en && snap_q[i]) flag_d[i] = 1'b0;
        if (hit[i])              flag_d[i] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q[i] <= 1'b0;
          snap_q[i] <= 1'b0;
        end else begin
          flag_q[i] <= flag_d[i];
          snap_q[i] <= snap_d[i];
        end
      end
    end
  endgenerate

  assign flags = flag_q;
endmodule

// File: rtl/sg_addr_ptr.sv
module sg_addr_ptr #(
  parameter int              ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] SR_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              rd_start,
  input  logic              rd_cur,
  input  logic              rd_done,
  output logic [ADDR_W-1:0] ptr,
  output logic              sr_rd_begin,
  output logic              sr_rd_end
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              act_q, act_d;
  logic [ADDR_W-1:0] target;
  logic              done_ok;

  always_comb begin
    target      = rd_cur ? ptr_q : bus_addr;
    done_ok     = rd_done && act_q;
    ptr_d       = ptr_q;
    act_d       = act_q;
    sr_rd_begin = 1'b0;
    sr_rd_end   = 1'b0;
    if (bus_wr) begin
      ptr_d = bus_addr + 1'b1;
      act_d = 1'b0;
    end else if (rd_start) begin
      ptr_d       = target;
      act_d       = 1'b1;
      sr_rd_begin = (target == SR_ADDR);
    end else if (done_ok) begin
      ptr_d     = ptr_q + 1'b1;
      act_d     = 1'b0;
      sr_rd_end = (ptr_q == SR_ADDR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      act_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      act_q <= act_d;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/stat_guard_reg.sv
module stat_guard_reg
  import sg_pkg::*;
#(
  parameter int              ADDR_W      = 6,
  parameter logic [ADDR_W-1:0] SR_ADDR     = 6'h3F,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              rd_start,
  input  logic              rd_cur,
  input  logic              rd_done,
  input  logic [N_ALM-1:0]  alm_hit,
  input  logic              on_backup,
  input  logic              osc_bad,
  input  logic              pwr_lost,
  output logic [BYTE_W-1:0] stat_byte,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              wr_permit,
  output logic              guard_we,
  output logic              wr_ack,
  output logic              op_end
);
  localparam int HW_W = 3;
  localparam logic [HW_W-1:0] HW_RST = 3'b001;

  logic             addr_is_sr;
  logic             wr_sr;
  logic             wel, rwel;
  logic [N_ALM-1:0] al_flags;
  logic             sr_rd_begin, sr_rd_end;
  logic [HW_W-1:0]  hw_raw, hw_sync;
  logic             op_end_q, op_end_d;

  assign addr_is_sr = (bus_addr == SR_ADDR);
  assign wr_sr      = bus_wr && addr_is_sr;

  sg_latch_seq u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_sr (wr_sr),
    .wdata (bus_wdata),
    .wel   (wel),
    .rwel  (rwel)
  );

  sg_addr_ptr #(
    .ADDR_W  (ADDR_W),
    .SR_ADDR (SR_ADDR)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .rd_start    (rd_start),
    .rd_cur      (rd_cur),
    .rd_done     (rd_done),
    .ptr         (cur_ptr),
    .sr_rd_begin (sr_rd_begin),
    .sr_rd_end   (sr_rd_end)
  );

  sg_alarm_bank #(
    .N (N_ALM)
  ) u_alm (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (alm_hit),
    .snap_en (sr_rd_begin),
    .clr_en  (sr_rd_end),
    .flags   (al_flags)
  );

  assign hw_raw = {on_backup, osc_bad, pwr_lost};

  sg_sync #(
    .W       (HW_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (HW_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hw_raw),
    .q     (hw_sync)
  );

  always_comb op_end_d = wr_sr || sr_rd_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_end_q <= 1'b0;
    else        op_end_q <= op_end_d;
  end

  always_comb begin
    stat_byte           = '0;
    stat_byte[POS_BAT]  = hw_sync[2];
    stat_byte[POS_AL1]  = al_flags[1];
    stat_byte[POS_AL0]  = al_flags[0];
    stat_byte[POS_OSCF] = hw_sync[1];
    stat_byte[POS_RSV]  = 1'b0;
    stat_byte[POS_RWEL] = rwel;
    stat_byte[POS_WEL]  = wel;
    stat_byte[POS_RTCF] = hw_sync[0];
  end

  assign wr_permit = wel && rwel;
  assign guard_we  = bus_wr && !addr_is_sr && wr_permit;
  assign wr_ack    = bus_wr;
  assign op_end    = op_end_q;
endmodule

// File: rtl/stat_guard_reg_chk.sv
module stat_guard_reg_chk #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] SR_ADDR = 6'h3F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              rd_start,
  input logic              rd_done,
  input logic [1:0]        alm_hit,
  input logic [7:0]        stat_byte,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic              wr_permit,
  input logic              guard_we,
  input logic              op_end,
  input logic              sr_rd_end
);
  // R3
  latch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_byte[2]) |-> $past(stat_byte[1]));

  // R4
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_byte[1]) |-> $past(bus_wr && bus_addr == SR_ADDR && bus_wdata == 8'h00));

  // R5
  guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_permit) |-> !guard_we);

  // R6
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit[0] |=> stat_byte[5]);

  // R7
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_byte[6]) |-> $past(rd_done));

  // R9
  wr_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> cur_ptr == ADDR_W'($past(bus_addr) + 1'b1));

  // R10
  op_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_end |-> $past((bus_wr && bus_addr == SR_ADDR) || sr_rd_end));
endmodule

bind stat_guard_reg stat_guard_reg_chk #(
  .ADDR_W  (ADDR_W),
  .SR_ADDR (SR_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .rd_start  (rd_start),
  .rd_done   (rd_done),
  .alm_hit   (alm_hit),
  .stat_byte (stat_byte),
  .cur_ptr   (cur_ptr),
  .wr_permit (wr_permit),
  .guard_we  (guard_we),
  .op_end    (op_end),
  .sr_rd_end (sr_rd_end)
);

// File: tb/stat_guard_reg_tb.sv
module stat_guard_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr, rd_start, rd_cur, rd_done;
  logic [1:0] alm_hit;
  logic       on_backup, osc_bad, pwr_lost;
  logic [7:0] stat_byte;
  logic [5:0] cur_ptr;
  logic       wr_permit, guard_we, wr_ack, op_end;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  stat_guard_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .rd_start(rd_start), .rd_cur(rd_cur), .rd_done(rd_done),
    .alm_hit(alm_hit), .on_backup(on_backup), .osc_bad(osc_bad),
    .pwr_lost(pwr_lost), .stat_byte(stat_byte), .cur_ptr(cur_ptr),
    .wr_permit(wr_permit), .guard_we(guard_we), .wr_ack(wr_ack), .op_end(op_end)
  );

  // {write data, expected WEL, expected RWEL}, walked from the reset state
  localparam int NVEC = 10;
  localparam logic [9:0] VEC [NVEC] = '{
    {8'h06, 1'b0, 1'b0},
    {8'h04, 1'b0, 1'b0},
    {8'h02, 1'b1, 1'b0},
    {8'h83, 1'b1, 1'b0},
    {8'h06, 1'b1, 1'b1},
    {8'h02, 1'b1, 1'b0},
    {8'h06, 1'b1, 1'b1},
    {8'hFF, 1'b1, 1'b1},
    {8'h40, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d,
                          output logic gw, output logic ack);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    gw = guard_we; ack = wr_ack;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_begin(input logic [5:0] a, input logic cur);
    bus_addr = a; rd_cur = cur; rd_start = 1'b1;
    tick();
    rd_start = 1'b0; rd_cur = 1'b0;
  endtask

  task automatic rd_end(input logic [1:0] hit);
    rd_done = 1'b1; alm_hit = hit;
    tick();
    rd_done = 1'b0; alm_hit = 2'b00;
  endtask

  task automatic pulse_alarm(input logic [1:0] hit);
    alm_hit = hit;
    tick();
    alm_hit = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic gw, ack;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 0; rd_start = 0;
    rd_cur = 0; rd_done = 0; alm_hit = 0; on_backup = 0; osc_bad = 0; pwr_lost = 0;
    repeat (3) tick();
    check("R1 reset status", stat_byte, 8'h01);
    check("R1 reset pointer", cur_ptr, 6'h00);
    check("R1 reset op_end", op_end, 1'b0);
    rst_n = 1'b1;
    tick(); tick();

    // R2 R3 R4: latch sequence table
    for (int i = 0; i < NVEC; i++) begin
      do_write(6'h3F, VEC[i][9:2], gw, ack);
      check($sformatf("R2/R3/R4 vec %0d WEL", i), stat_byte[1], VEC[i][1]);
      check($sformatf("R2/R3/R4 vec %0d RWEL", i), stat_byte[2], VEC[i][0]);
      check("R10 op_end after status write", op_end, 1'b1);
      check("R5 status write not guarded", gw, 1'b0);
    end
    tick();
    check("R10 op_end single cycle", op_end, 1'b0);

    // R5: guarded writes
    do_write(6'h05, 8'hAA, gw, ack);
    check("R5 disarmed write discarded", gw, 1'b0);
    check("R5 discarded write acked", ack, 1'b1);
    check("R9 write pointer", cur_ptr, 6'h06);
    check("R10 no op_end off status", op_end, 1'b0);
    do_write(6'h3F, 8'h02, gw, ack);
    do_write(6'h05, 8'hAA, gw, ack);
    check("R5 WEL only discarded", gw, 1'b0);
    check("R5 permit low with WEL only", wr_permit, 1'b0);
    do_write(6'h3F, 8'h06, gw, ack);
    check("R5 permit high when armed", wr_permit, 1'b1);
    do_write(6'h05, 8'h55, gw, ack);
    check("R5 armed write passes", gw, 1'b1);
    check("R5 armed write acked", ack, 1'b1);

    // R6 R7: alarm flags
    pulse_alarm(2'b01);
    check("R6 alarm0 set", stat_byte[6:5], 2'b01);
    rd_begin(6'h3F, 1'b0);
    check("R9 read start loads pointer", cur_ptr, 6'h3F);
    pulse_alarm(2'b10);
    check("R6 alarm1 set", stat_byte[6:5], 2'b11);
    rd_end(2'b00);
    check("R7 only pre-read flag cleared", stat_byte[6:5], 2'b10);
    check("R9 pointer wraps after status", cur_ptr, 6'h00);
    check("R10 op_end after status read", op_end, 1'b1);

    rd_begin(6'h3F, 1'b0);
    rd_end(2'b10);
    check("R7 same-cycle alarm wins", stat_byte[6:5], 2'b10);

    rd_begin(6'h10, 1'b0);
    rd_end(2'b00);
    check("R7 other-address read keeps flag", stat_byte[6:5], 2'b10);
    check("R9 pointer advances", cur_ptr, 6'h11);
    check("R10 no op_end other read", op_end, 1'b0);

    rd_begin(6'h30, 1'b1);
    check("R9 current-address read", cur_ptr, 6'h11);
    rd_end(2'b00);
    check("R9 current read advances", cur_ptr, 6'h12);
    rd_end(2'b00);
    check("R9 stray rd_done ignored", cur_ptr, 6'h12);

    rd_begin(6'h3F, 1'b0);
    rd_end(2'b00);
    check("R7 alarm1 cleared on later read", stat_byte[6:5], 2'b00);

    // R8: hardware-owned bits
    on_backup = 1'b1; osc_bad = 1'b1; pwr_lost = 1'b1;
    tick();
    check("R8 one edge early", stat_byte & 8'h91, 8'h00);
    tick();
    check("R8 after two edges", stat_byte & 8'h91, 8'h91);
    do_write(6'h3F, 8'h00, gw, ack);
    check("R8 write leaves hw bits", stat_byte & 8'h99, 8'h91);
    do_write(6'h3F, 8'hFF, gw, ack);
    check("R8 write ones leaves hw bits", stat_byte & 8'h99, 8'h91);
    check("R4 other value keeps latches", stat_byte[2:1], 2'b00);
    on_backup = 1'b0;
    tick(); tick();
    check("R8 backup bit drops", stat_byte[7], 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule